// File: doc/BRIEF.md
# Write-Masked Indirect PHY Configuration Port

This block is a small register slave that sits between a simple single-cycle register bus and the configuration side of a multi-lane serial PHY. It holds three word locations: a control word that carries an indirect configuration address, a data nibble and a write strobe; a lane power word that idles or activates each lane; and a read-only status word. Writes to the two writable words are bit-masked. The upper halfword of every written value says which low bits may change, so software can update one field without a read-modify-write.

PHY configuration entries are never reached directly. Software first loads the address and data fields, then raises the strobe bit. The rising edge of the strobe commits the data into a 64-entry by 4-bit configuration array. To read an entry, software loads the address field and then reads the status word. The status word returns the selected entry together with two flags from a behavioural PLL model. One flag shows that the PLL is locked. The other shows that the output enable is still pending. The pending flag clears after a rate-select entry is programmed, and the PLL then re-locks. When the selected address falls in the lane status window, the status word also carries that lane's receiver-detect state.

Top module: `phy_cfg_port`

## Requirements
- R1: On a write to the control word (offset 0) or the lane word (offset 1), low bit x takes bit x of the written value only when bit x+16 is 1. Every other low bit keeps its value, so a write with an all-zero upper halfword changes nothing.
- R2: After reset all low-halfword register bits are 0. Reads of the control and lane words return 0 in bits 31:16, and status bits 31:12 always read 0.
- R3: In the control word, bit 0 is the strobe, bits 6:1 are the 6-bit entry address and bits 10:7 are the 4-bit entry data. A 0-to-1 transition of the strobe writes the data field into the array entry at the address field, using the field values produced by that same write.
- R4: A write that leaves the strobe at 1 when it was already 1 does not write the array, even if the address or data fields change.
- R5: Status (offset 2) bits 3:0 return the array entry at the address currently held in control bits 6:1.
- R6: Status bit 9 (locked) rises LOCK_DLY cycles after reset is released.
- R7: Status bit 10 (output pending) is 1 from reset. A committed array write to address 0x12 with data bit 3 set starts a countdown, and OUT_DLY-1 edges later pending clears and stays clear. On that same edge locked drops, and it rises again LOCK_DLY cycles later.
- R8: Lane word bits 3, 4, 5 and 6 idle lanes 0, 1, 2 and 3 when 1. When the selected address is 0x30+n for a lane n, status bit 11 shows that lane's receiver-detect input only while the lane is not idled. For any other address bit 11 is 0.
- R9: Writes to the status offset change nothing, and reads of an unmapped offset return 0.
- R10: Read data appears on the bus one cycle after the read request and is 0 in any cycle after no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request, one cycle per write |
| bus_rd | input | 1 | Read request, one cycle per read |
| bus_addr | input | ADDR_W | Word offset (0 control, 1 lane, 2 status) |
| bus_wdata | input | 32 | Write value, upper halfword is the bit mask |
| bus_rdata | output | 32 | Registered read data |
| lane_rx_det | input | LANES | Receiver-detect state per lane |

## Verification
The assertions take it that reads and writes are single-cycle requests with a stable offset and value in that cycle, and that the lane receiver-detect inputs change only between clock edges. The stimulus drives all inputs on the falling clock edge and holds each request for exactly one cycle. Every write uses explicit mask halfwords, including all-zero masks, held strobes and rewrites of the strobe bit alone. Because the reset release, the rate-select write and every read are single well-placed events, the PLL countdown and re-lock windows are reached from known starting points.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [BUS_W-1:0]  word_t;

  localparam int ST_LOCK_BIT = 9;
  localparam int ST_PEND_BIT = 10;
  localparam int ST_RXD_BIT  = 11;
endpackage

// File: rtl/hw_mask_reg.sv
module hw_mask_reg #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2*HW-1:0] wval,
  output logic [HW-1:0]   q,
  output logic [HW-1:0]   q_nxt
);
  logic [HW-1:0] msk;
  logic [HW-1:0] val;

  always_comb begin
    msk   = wval[2*HW-1:HW];
    val   = wval[HW-1:0];
    q_nxt = (q & ~msk) | (val & msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= q_nxt;
  end
endmodule

// File: rtl/phy_cfg_array.sv
module phy_cfg_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[i] <= '0;
      else if (we && (waddr == AW'(i)))      mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pll_flag_model.sv
module pll_flag_model #(
  parameter int LOCK_DLY = 20,
  parameter int OUT_DLY  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic locked,
  output logic pending
);
  localparam int LW = $clog2(LOCK_DLY + 1);
  localparam int OW = (OUT_DLY > 1) ? $clog2(OUT_DLY) : 1;
  localparam logic [LW-1:0] LOCK_END = LW'(LOCK_DLY);
  localparam logic [OW-1:0] OUT_END  = OW'(OUT_DLY - 1);

  logic [LW-1:0] lock_cnt, lock_cnt_nxt;
  logic [OW-1:0] out_cnt, out_cnt_nxt;
  logic          armed, armed_nxt;
  logic          pend_q, pend_nxt;
  logic          done;

  always_comb begin
    done         = armed && (out_cnt == OUT_END);
    armed_nxt    = armed;
    out_cnt_nxt  = out_cnt;
    pend_nxt     = pend_q;
    lock_cnt_nxt = lock_cnt;
    if (armed) begin
      if (done) begin
        armed_nxt = 1'b0;
        pend_nxt  = 1'b0;
      end else begin
        out_cnt_nxt = out_cnt + 1'b1;
      end
    end else if (trigger && pend_q) begin
      armed_nxt   = 1'b1;
      out_cnt_nxt = '0;
    end
    if (done)                       lock_cnt_nxt = '0;
    else if (lock_cnt != LOCK_END)  lock_cnt_nxt = lock_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
      out_cnt  <= '0;
      armed    <= 1'b0;
      pend_q   <= 1'b1;
    end else begin
      lock_cnt <= lock_cnt_nxt;
      out_cnt  <= out_cnt_nxt;
      armed    <= armed_nxt;
      pend_q   <= pend_nxt;
    end
  end

  assign locked  = (lock_cnt == LOCK_END);
  assign pending = pend_q;
endmodule

// File: rtl/phy_cfg_port.sv
module phy_cfg_port
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CFG_OFS   = 0,
  parameter int LANE_OFS  = 1,
  parameter int STAT_OFS  = 2,
  parameter int CA_W      = 6,
  parameter int CD_W      = 4,
  parameter int LANES     = 4,
  parameter int IDLE_LSB  = 3,
  parameter int LANE_BASE = 'h30,
  parameter int RATE_ADDR = 'h12,
  parameter int RATE_BIT  = 3,
  parameter int LOCK_DLY  = 20,
  parameter int OUT_DLY   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [LANES-1:0]  lane_rx_det
);
  localparam int STB_BIT  = 0;
  localparam int ADDR_LSB = 1;
  localparam int DATA_LSB = ADDR_LSB + CA_W;
  localparam int LIDX_W   = (LANES > 1) ? $clog2(LANES) : 1;

  logic         cfg_we, lane_we;
  half_t        cfg_q, cfg_nxt, lane_q, lane_nxt;
  logic         arr_we, pll_trig, locked, pending;
  logic [CA_W-1:0] sel_addr, wr_addr, lane_diff;
  logic [CD_W-1:0] wr_data, entry;
  logic [LIDX_W-1:0] lane_idx;
  logic         lane_hit, rxd_bit;
  word_t        status, rdata_nxt;
  logic         unused_bits;

  assign cfg_we  = bus_wr && (bus_addr == ADDR_W'(CFG_OFS));
  assign lane_we = bus_wr && (bus_addr == ADDR_W'(LANE_OFS));

  hw_mask_reg #(.HW(HALF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wval(bus_wdata),
    .q(cfg_q), .q_nxt(cfg_nxt));

  hw_mask_reg #(.HW(HALF_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .we(lane_we), .wval(bus_wdata),
    .q(lane_q), .q_nxt(lane_nxt));

  assign unused_bits = ^{lane_nxt, cfg_nxt[HALF_W-1:DATA_LSB+CD_W]};

  // strobe commit on 0 -> 1 transition only
  assign wr_addr  = cfg_nxt[DATA_LSB-1:ADDR_LSB];
  assign wr_data  = cfg_nxt[DATA_LSB+CD_W-1:DATA_LSB];
  assign arr_we   = cfg_we && cfg_nxt[STB_BIT] && !cfg_q[STB_BIT];
  assign pll_trig = arr_we && (wr_addr == CA_W'(RATE_ADDR)) && wr_data[RATE_BIT];
  assign sel_addr = cfg_q[DATA_LSB-1:ADDR_LSB];

  phy_cfg_array #(.AW(CA_W), .DW(CD_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(wr_addr),
    .wdata(wr_data), .raddr(sel_addr), .rdata(entry));

  pll_flag_model #(.LOCK_DLY(LOCK_DLY), .OUT_DLY(OUT_DLY)) u_pll (
    .clk(clk), .rst_n(rst_n), .trigger(pll_trig),
    .locked(locked), .pending(pending));

  always_comb begin
    lane_diff = sel_addr - CA_W'(LANE_BASE);
    lane_idx  = lane_diff[LIDX_W-1:0];
    lane_hit  = (sel_addr >= CA_W'(LANE_BASE)) && (lane_diff < CA_W'(LANES));
    rxd_bit   = lane_hit && lane_rx_det[lane_idx] && !lane_q[IDLE_LSB + int'(lane_idx)];
    status    = '0;
    status[CD_W-1:0]   = entry;
    status[ST_LOCK_BIT] = locked;
    status[ST_PEND_BIT] = pending;
    status[ST_RXD_BIT]  = rxd_bit;
  end

  always_comb begin
    rdata_nxt = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(CFG_OFS))       rdata_nxt = {{HALF_W{1'b0}}, cfg_q};
      else if (bus_addr == ADDR_W'(LANE_OFS)) rdata_nxt = {{HALF_W{1'b0}}, lane_q};
      else if (bus_addr == ADDR_W'(STAT_OFS)) rdata_nxt = status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_nxt;
  end
endmodule

module phy_cfg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        cfg_we,
  input logic        lane_we,
  input logic [15:0] cfg_q,
  input logic [15:0] lane_q,
  input logic        arr_we,
  input logic        locked,
  input logic        pending
);
  assert_cfg_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && bus_wdata[31:16] == 16'd0) |=> $stable(cfg_q));
  assert_lane_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && bus_wdata[31:16] == 16'd0) |=> $stable(lane_q));
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:12] == 20'd0);
  assert_strobe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> cfg_q[0]);
  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !cfg_q[0]);
  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !pending);
  assert_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> !locked);
  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);
endmodule

bind phy_cfg_port phy_cfg_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cfg_we(cfg_we), .lane_we(lane_we),
  .cfg_q(cfg_q), .lane_q(lane_q), .arr_we(arr_we),
  .locked(locked), .pending(pending));

// File: tb/phy_cfg_port_tb_top.sv
`timescale 1ns/1ps
module phy_cfg_port_tb_top;
  localparam int LOCK_DLY = 20;
  localparam int OUT_DLY  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  lane_rx_det = 4'b1111;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R2";

  phy_cfg_port #(.LOCK_DLY(LOCK_DLY), .OUT_DLY(OUT_DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lane_rx_det(lane_rx_det));

  always #5 clk = ~clk;

  // behavioural reference model
  int m_arr [64];
  int m_cfg, m_lane, m_rdata;
  int m_lcnt, m_ocnt;
  bit m_armed, m_pend;

  function automatic int masked(int cur, int w);
    int msk = (w >>> 16) & 'hFFFF;
    return (cur & ~msk & 'hFFFF) | (w & msk & 'hFFFF);
  endfunction

  function automatic int m_status();
    int a = (m_cfg >> 1) & 'h3F;
    int s = m_arr[a];
    if (m_lcnt == LOCK_DLY) s |= (1 << 9);
    if (m_pend) s |= (1 << 10);
    if (a >= 'h30 && a <= 'h33)
      if (lane_rx_det[a - 'h30] && !((m_lane >> (3 + a - 'h30)) & 1)) s |= (1 << 11);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_arr[i]) m_arr[i] = 0;
      m_cfg = 0; m_lane = 0; m_rdata = 0;
      m_lcnt = 0; m_ocnt = 0; m_armed = 0; m_pend = 1;
    end else begin
      int ncfg;
      bit trig, done;
      m_rdata = 0;
      if (bus_rd)
        case (bus_addr)
          0: m_rdata = m_cfg;
          1: m_rdata = m_lane;
          2: m_rdata = m_status();
          default: m_rdata = 0;
        endcase
      trig = 0;
      ncfg = m_cfg;
      if (bus_wr && bus_addr == 0) begin
        ncfg = masked(m_cfg, bus_wdata);
        if ((ncfg & 1) && !(m_cfg & 1)) begin
          m_arr[(ncfg >> 1) & 'h3F] = (ncfg >> 7) & 'hF;
          trig = (((ncfg >> 1) & 'h3F) == 'h12) && ((ncfg >> 10) & 1);
        end
      end
      m_cfg = ncfg;
      if (bus_wr && bus_addr == 1) m_lane = masked(m_lane, bus_wdata);
      done = m_armed && (m_ocnt == OUT_DLY - 1);
      if (m_armed) begin
        if (done) begin m_armed = 0; m_pend = 0; end
        else m_ocnt++;
      end else if (trig && m_pend) begin
        m_armed = 1; m_ocnt = 0;
      end
      if (done) m_lcnt = 0;
      else if (m_lcnt < LOCK_DLY) m_lcnt++;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_chk++;
      if (bus_rdata !== 32'(m_rdata)) begin
        n_fail++;
        $display("FAIL %s cycle %0d: rdata actual %h expected %h", phase, cyc, bus_rdata, m_rdata);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_rd = 1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int v;

  initial begin
    idle(3);
    rst_n = 1'b1;
    phase = "R2";
    rd(0, v); chk("R2 cfg reset", v, 0);
    rd(1, v); chk("R2 lane reset", v, 0);
    rd(2, v); chk("R2 status reset (pending only)", v, 'h400);

    phase = "R1";
    wr(0, 'h0000_07FE); rd(0, v); chk("R1 zero mask cfg", v, 0);
    wr(1, 'h0078_0078); rd(1, v); chk("R1 lane set", v, 'h78);
    wr(1, 'h0000_0000); rd(1, v); chk("R1 zero mask lane", v, 'h78);
    wr(1, 'h0010_0000); rd(1, v); chk("R1 single bit clear", v, 'h68);
    wr(1, 'h0000_FFFF); rd(1, v); chk("R1 unmasked ones ignored", v, 'h68);

    phase = "R3";
    wr(0, 'h07FE_0000 | ('hA << 7) | (5 << 1));
    wr(0, 'h0001_0001);
    wr(0, 'h0001_0000);
    rd(2, v); chk("R3 entry 5 written", v & 'hF, 'hA);
    wr(0, 'h0781_0000 | (3 << 7) | 1);
    rd(2, v); chk("R3 addr+data+strobe in one write", v & 'hF, 3);
    rd(0, v); chk("R3 cfg fields", v, (3 << 7) | (5 << 1) | 1);

    phase = "R4";
    wr(0, 'h0781_0000 | (7 << 7) | 1);
    rd(2, v); chk("R4 held strobe no rewrite", v & 'hF, 3);

    phase = "R5";
    wr(0, 'h07FE_0000 | (9 << 1));
    rd(2, v); chk("R5 entry 9 empty", v & 'hF, 0);
    wr(0, 'h07FE_0000 | (5 << 1));
    rd(2, v); chk("R5 entry 5 readback", v & 'hF, 3);

    phase = "R8";
    wr(0, 'h07E_0000 | ('h31 << 1));
    rd(2, v); chk("R8 lane 1 active rxdet", (v >> 11) & 1, 1);
    wr(0, 'h07E_0000 | ('h30 << 1));
    rd(2, v); chk("R8 lane 0 idled rxdet", (v >> 11) & 1, 0);
    wr(0, 'h07E_0000 | ('h35 << 1));
    rd(2, v); chk("R8 outside lane window", (v >> 11) & 1, 0);
    lane_rx_det = 4'b0000;
    wr(0, 'h07E_0000 | ('h31 << 1));
    rd(2, v); chk("R8 no receiver", (v >> 11) & 1, 0);

    phase = "R6";
    idle(LOCK_DLY + 5);
    rd(2, v); chk("R6 locked", (v >> 9) & 1, 1);

    phase = "R7";
    wr(0, 'h0001_0000);
    wr(0, 'h07FF_0000 | (8 << 7) | ('h12 << 1) | 1);
    rd(2, v); chk("R7 still pending", (v >> 10) & 1, 1);
    idle(OUT_DLY + 2);
    rd(2, v); chk("R7 pending cleared", (v >> 10) & 1, 0);
    chk("R7 lock dropped", (v >> 9) & 1, 0);
    idle(LOCK_DLY + 2);
    rd(2, v); chk("R7 relocked", (v >> 9) & 1, 1);

    phase = "R9";
    wr(2, 'hFFFF_FFFF);
    rd(2, v); chk("R9 status write ignored", v & 'hF, 8);
    rd(7, v); chk("R9 unmapped read", v, 0);

    phase = "R10";
    idle(1);
    chk("R10 rdata idle", bus_rdata, 0);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule